// File: doc/BRIEF.md
# Pulse-Width Serial Frame Receiver

This block is the listening half of a slave node on a single-wire bus. The bus idles high and carries every symbol as one low pulse. The width of that pulse says whether the symbol is a frame start (sync), a logic 0 or a logic 1. The block first brings the raw line into the clock domain. It then times each low pulse in clock cycles and sorts it into a class using two thresholds that software supplies. After a sync, it collects the fixed-length frame that follows.

Once the final parity bit arrives, the block splits the frame into four fields: the transfer direction, the target node address, the register address and the data byte. It checks the header parity and the data parity and issues one response decision. The decision is ACK only when the node address matches the local address and nothing in the frame was faulty. In that case a one-cycle frame-valid strobe also fires. A faulty frame is answered with NACK and an error strobe. The pulse in the acknowledge slot that follows the frame is consumed, and the block then waits for the next sync.

Top module: `bsd_frame_rx`

## Requirements
- R1: The line input passes through a two-stage synchroniser. The response strobe rises at the fourth falling clock edge after the line rises at the end of the last parity pulse, and it is still low at the third.
- R2: A low pulse of width w cycles is classified as follows. It is invalid if w < 2 (MIN_W). It is a 1 if 2 <= w < thr_short_i. It is a 0 if thr_short_i <= w <= thr_long_i. It is a sync if w > thr_long_i. Both thresholds can be changed at run time.
- R3: While no frame is open, every pulse other than a sync is ignored and produces no response.
- R4: After a sync, 18 bits arrive MSB first in this order: direction (1), node address (3), register address (4), header parity (1), data (8), data parity (1). The fields appear on dir_o, saddr_o, raddr_o and data_o.
- R5: The header parity bit makes the XOR of the direction, node-address, register-address and parity bits equal 0 (even parity). A mismatch gives NACK with err_o.
- R6: The data parity bit makes the XOR of the data and parity bits equal 0. A mismatch gives NACK with err_o.
- R7: An invalid-width pulse inside a frame takes up its bit slot and makes that frame end in NACK with err_o.
- R8: A sync that arrives inside a frame throws away the bits already collected and starts a new frame.
- R9: frame_vld_o and resp_ack_o pulse only when saddr matches node_addr_i and no fault was seen. A frame for another node gets a NACK response without err_o.
- R10: The field outputs change only in the cycle of a response strobe. At all other times they hold their values.
- R11: After a decision, one pulse is taken as the acknowledge slot. A new decision needs a new sync, so resp_vld_o is never high on two consecutive cycles.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous bus line, idle high |
| thr_short_i | input | CNT_W | Lowest width that decodes as 0 |
| thr_long_i | input | CNT_W | Highest width that decodes as 0 |
| node_addr_i | input | SA_W | Local node address |
| dir_o | output | 1 | Direction bit of the last frame |
| saddr_o | output | SA_W | Node address of the last frame |
| raddr_o | output | RA_W | Register address of the last frame |
| data_o | output | D_W | Data byte of the last frame |
| frame_vld_o | output | 1 | One-cycle strobe for an addressed, fault-free frame |
| resp_vld_o | output | 1 | One-cycle strobe marking a response decision |
| resp_ack_o | output | 1 | Decision: 1 = ACK, 0 = NACK (valid with resp_vld_o) |
| err_o | output | 1 | One-cycle strobe for a parity or width fault |

## Verification
The bench uses the default field widths (3, 4, 8) and an 8-bit width counter. It also uses MIN_W = 2 and node address 5, with thresholds of 6 and 12 cycles. These short widths keep each frame at a few hundred cycles, so many frames fit in one run. They also let every class boundary be hit exactly: widths 1, 2, thr_short-1, thr_short, thr_long and thr_long+1. Partway through, the thresholds are lowered to 3 and 8. This shows that a width which meant 1 now decodes as 0 and that a shorter pulse now acts as a sync.

// File: rtl/bsd_rx_pkg.sv
package bsd_rx_pkg;
  typedef enum logic [1:0] {
    SYM_ONE  = 2'd0,
    SYM_ZERO = 2'd1,
    SYM_SYNC = 2'd2,
    SYM_BAD  = 2'd3
  } sym_e;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_BITS = 2'd1,
    ST_ACK  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/bsd_line_meter.sv
module bsd_line_meter #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             line_i,
  output logic             pulse_end_o,
  output logic [CNT_W-1:0] width_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   line_s;

  assign line_s = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '1;
        else       sync_q <= line_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '1;
        else       sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      prev_q <= line_s;
      if (line_s)              cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pulse_end_o = line_s & ~prev_q;
  assign width_o     = cnt_q;
endmodule

// File: rtl/bsd_sym_classify.sv
module bsd_sym_classify
  import bsd_rx_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int MIN_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             pulse_end_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] thr_short_i,
  input  logic [CNT_W-1:0] thr_long_i,
  output logic             sym_vld_o,
  output sym_e             sym_o
);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_W);

  sym_e sym_d;

  always_comb begin
    if (width_i < MIN_CNT)           sym_d = SYM_BAD;
    else if (width_i < thr_short_i)  sym_d = SYM_ONE;
    else if (width_i <= thr_long_i)  sym_d = SYM_ZERO;
    else                             sym_d = SYM_SYNC;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sym_vld_o <= 1'b0;
      sym_o     <= SYM_ONE;
    end else begin
      sym_vld_o <= pulse_end_i;
      if (pulse_end_i) sym_o <= sym_d;
    end
  end
endmodule

// File: rtl/bsd_frame_parse.sv
module bsd_frame_parse
  import bsd_rx_pkg::*;
#(
  parameter int SA_W = 3,
  parameter int RA_W = 4,
  parameter int D_W  = 8
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            sym_vld_i,
  input  sym_e            sym_i,
  input  logic [SA_W-1:0] node_addr_i,
  output logic            dir_o,
  output logic [SA_W-1:0] saddr_o,
  output logic [RA_W-1:0] raddr_o,
  output logic [D_W-1:0]  data_o,
  output logic            frame_vld_o,
  output logic            resp_vld_o,
  output logic            resp_ack_o,
  output logic            err_o
);
  localparam int FRAME_BITS = SA_W + RA_W + D_W + 3;
  localparam int BC_W       = $clog2(FRAME_BITS + 1);
  localparam int D_LSB      = 1;
  localparam int P1_POS     = D_W + 1;
  localparam int RA_LSB     = P1_POS + 1;
  localparam int SA_LSB     = RA_LSB + RA_W;
  localparam int DIR_POS    = FRAME_BITS - 1;
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(FRAME_BITS - 1);

  rx_state_e             state_q;
  logic [BC_W-1:0]       bit_cnt_q;
  logic [FRAME_BITS-2:0] shreg_q;
  logic                  bad_q;

  logic                  bit_val;
  logic                  is_sync;
  logic                  is_bad;
  logic [FRAME_BITS-1:0] full_frame;
  logic                  hdr_fail;
  logic                  dat_fail;
  logic                  addr_hit;
  logic                  fault;

  assign bit_val    = (sym_i == SYM_ONE);
  assign is_sync    = (sym_i == SYM_SYNC);
  assign is_bad     = (sym_i == SYM_BAD);
  assign full_frame = {shreg_q, bit_val};
  assign hdr_fail   = ^full_frame[DIR_POS:P1_POS];
  assign dat_fail   = ^full_frame[P1_POS-1:0];
  assign addr_hit   = (full_frame[SA_LSB +: SA_W] == node_addr_i);
  assign fault      = bad_q | is_bad | hdr_fail | dat_fail;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q     <= ST_HUNT;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      bad_q       <= 1'b0;
      dir_o       <= 1'b0;
      saddr_o     <= '0;
      raddr_o     <= '0;
      data_o      <= '0;
      frame_vld_o <= 1'b0;
      resp_vld_o  <= 1'b0;
      resp_ack_o  <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      frame_vld_o <= 1'b0;
      resp_vld_o  <= 1'b0;
      resp_ack_o  <= 1'b0;
      err_o       <= 1'b0;
      if (sym_vld_i) begin
        if (is_sync) begin
          state_q   <= ST_BITS;
          bit_cnt_q <= '0;
          bad_q     <= 1'b0;
        end else begin
          case (state_q)
            ST_BITS: begin
              shreg_q <= full_frame[FRAME_BITS-2:0];
              bad_q   <= bad_q | is_bad;
              if (bit_cnt_q == LAST_BIT) begin
                state_q     <= ST_ACK;
                dir_o       <= full_frame[DIR_POS];
                saddr_o     <= full_frame[SA_LSB +: SA_W];
                raddr_o     <= full_frame[RA_LSB +: RA_W];
                data_o      <= full_frame[D_LSB +: D_W];
                resp_vld_o  <= 1'b1;
                resp_ack_o  <= addr_hit & ~fault;
                frame_vld_o <= addr_hit & ~fault;
                err_o       <= fault;
              end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
            ST_ACK:  state_q <= ST_HUNT;
            default: state_q <= ST_HUNT;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/bsd_frame_rx.sv
module bsd_frame_rx
  import bsd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int MIN_W       = 2,
  parameter int SA_W        = 3,
  parameter int RA_W        = 4,
  parameter int D_W         = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             line_i,
  input  logic [CNT_W-1:0] thr_short_i,
  input  logic [CNT_W-1:0] thr_long_i,
  input  logic [SA_W-1:0]  node_addr_i,
  output logic             dir_o,
  output logic [SA_W-1:0]  saddr_o,
  output logic [RA_W-1:0]  raddr_o,
  output logic [D_W-1:0]   data_o,
  output logic             frame_vld_o,
  output logic             resp_vld_o,
  output logic             resp_ack_o,
  output logic             err_o
);
  logic             pulse_end;
  logic [CNT_W-1:0] pulse_width;
  logic             sym_vld;
  sym_e             sym_cls;

  bsd_line_meter #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_meter (
    .clk_i(clk_i), .rst_i(rst_i), .line_i(line_i),
    .pulse_end_o(pulse_end), .width_o(pulse_width)
  );

  bsd_sym_classify #(.CNT_W(CNT_W), .MIN_W(MIN_W)) u_cls (
    .clk_i(clk_i), .rst_i(rst_i), .pulse_end_i(pulse_end),
    .width_i(pulse_width), .thr_short_i(thr_short_i), .thr_long_i(thr_long_i),
    .sym_vld_o(sym_vld), .sym_o(sym_cls)
  );

  bsd_frame_parse #(.SA_W(SA_W), .RA_W(RA_W), .D_W(D_W)) u_parse (
    .clk_i(clk_i), .rst_i(rst_i), .sym_vld_i(sym_vld), .sym_i(sym_cls),
    .node_addr_i(node_addr_i), .dir_o(dir_o), .saddr_o(saddr_o),
    .raddr_o(raddr_o), .data_o(data_o), .frame_vld_o(frame_vld_o),
    .resp_vld_o(resp_vld_o), .resp_ack_o(resp_ack_o), .err_o(err_o)
  );
endmodule

// File: rtl/bsd_frame_rx_chk.sv
module bsd_frame_rx_chk
  import bsd_rx_pkg::*;
#(
  parameter int SA_W = 3,
  parameter int RA_W = 4,
  parameter int D_W  = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            sym_vld,
  input sym_e            sym_cls,
  input logic [SA_W-1:0] node_addr,
  input logic            dir,
  input logic [SA_W-1:0] saddr,
  input logic [RA_W-1:0] raddr,
  input logic [D_W-1:0]  data,
  input logic            frame_vld,
  input logic            resp_vld,
  input logic            resp_ack,
  input logic            err
);
  AST_VALID_IS_ACK: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> resp_vld && resp_ack); // R9
  AST_ACK_ADDR_HIT: assert property (@(posedge clk) disable iff (rst)
    (resp_vld && resp_ack) |-> (saddr == node_addr) && !err); // R9
  AST_ERR_IS_NACK: assert property (@(posedge clk) disable iff (rst)
    err |-> resp_vld && !resp_ack); // R7
  AST_DECIDE_ON_BIT: assert property (@(posedge clk) disable iff (rst)
    resp_vld |-> $past(sym_vld) && ($past(sym_cls) != SYM_SYNC)); // R8
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
    !resp_vld |-> $stable(data) && $stable(saddr) && $stable(raddr) && $stable(dir)); // R10
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    resp_vld |=> !resp_vld); // R11
endmodule

bind bsd_frame_rx bsd_frame_rx_chk #(.SA_W(SA_W), .RA_W(RA_W), .D_W(D_W)) u_chk (
  .clk(clk_i), .rst(rst_i), .sym_vld(sym_vld), .sym_cls(sym_cls),
  .node_addr(node_addr_i), .dir(dir_o), .saddr(saddr_o), .raddr(raddr_o),
  .data(data_o), .frame_vld(frame_vld_o), .resp_vld(resp_vld_o),
  .resp_ack(resp_ack_o), .err(err_o)
);

// File: tb/bsd_frame_rx_tb.sv
module bsd_frame_rx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_i = 1'b1;
  logic [7:0] thr_short = 8'd6;
  logic [7:0] thr_long  = 8'd12;
  logic [2:0] node_addr = 3'd5;
  logic       dir_o;
  logic [2:0] saddr_o;
  logic [3:0] raddr_o;
  logic [7:0] data_o;
  logic       frame_vld_o, resp_vld_o, resp_ack_o, err_o;

  int checks = 0;
  int errors = 0;
  int n_resp = 0;
  int w1 = 4, w0 = 9, wsync = 20;
  logic cap_vld, cap_fv, cap_ack, cap_err, cap_early;

  always #10 clk = ~clk;

  bsd_frame_rx u_dut (
    .clk_i(clk), .rst_i(rst), .line_i(line_i), .thr_short_i(thr_short),
    .thr_long_i(thr_long), .node_addr_i(node_addr), .dir_o(dir_o),
    .saddr_o(saddr_o), .raddr_o(raddr_o), .data_o(data_o),
    .frame_vld_o(frame_vld_o), .resp_vld_o(resp_vld_o),
    .resp_ack_o(resp_ack_o), .err_o(err_o)
  );

  always @(negedge clk) if (!rst && resp_vld_o) n_resp++;

  // {dir, saddr[3], raddr[4], data[8], flip_hdr_par, flip_dat_par}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 3'd5, 4'h3, 8'hA5, 1'b0, 1'b0},
    {1'b1, 3'd5, 4'hF, 8'h00, 1'b0, 1'b0},
    {1'b0, 3'd2, 4'h1, 8'h3C, 1'b0, 1'b0},
    {1'b0, 3'd5, 4'h7, 8'hFF, 1'b1, 1'b0},
    {1'b1, 3'd5, 4'h0, 8'h81, 1'b0, 1'b1},
    {1'b1, 3'd5, 4'hA, 8'h7E, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_pulse(input int w);
    line_i = 1'b0;
    repeat (w) @(negedge clk);
    line_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input logic d, input logic [2:0] sa, input logic [3:0] ra,
                            input logic [7:0] dat, input logic f1, input logic f2,
                            input int bad_idx);
    logic [17:0] bits;
    bits = {d, sa, ra, (^{d, sa, ra}) ^ f1, dat, (^dat) ^ f2};
    send_pulse(wsync);
    for (int i = 0; i < 18; i++) begin
      int w;
      w = (i == bad_idx) ? 1 : (bits[17-i] ? w1 : w0);
      if (i < 17) send_pulse(w);
      else begin
        line_i = 1'b0;
        repeat (w) @(negedge clk);
        line_i = 1'b1;
        repeat (3) @(negedge clk);
        cap_early = resp_vld_o;
        @(negedge clk);
        cap_vld = resp_vld_o; cap_fv = frame_vld_o;
        cap_ack = resp_ack_o; cap_err = err_o;
        repeat (3) @(negedge clk);
      end
    end
    send_pulse(w1);
  endtask

  task automatic do_reset();
    rst = 1'b1; line_i = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    @(negedge clk);
    do_reset();
    chk("R12 frame_vld", frame_vld_o, 0);
    chk("R12 resp_vld", resp_vld_o, 0);
    chk("R12 err", err_o, 0);
    chk("R12 data", data_o, 0);
    chk("R12 saddr", saddr_o, 0);

    for (int i = 0; i < 6; i++) begin
      logic [17:0] v;
      logic hit, flt;
      v = VEC[i];
      send_frame(v[17], v[16:14], v[13:10], v[9:2], v[1], v[0], -1);
      hit = (v[16:14] == node_addr);
      flt = v[1] | v[0];
      chk("R1 latency early", cap_early, 0);
      chk("R1 latency", cap_vld, 1);
      chk("R9 frame_vld", cap_fv, hit & ~flt);
      chk("R9 ack", cap_ack, hit & ~flt);
      chk("R5 R6 err", cap_err, flt);
      chk("R4 dir", dir_o, v[17]);
      chk("R4 saddr", saddr_o, v[16:14]);
      chk("R4 raddr", raddr_o, v[13:10]);
      chk("R4 data", data_o, v[9:2]);
    end

    // R3: pulses with no sync after reset are ignored
    do_reset();
    base = n_resp;
    for (int i = 0; i < 20; i++) send_pulse((i % 2) ? w1 : w0);
    chk("R3 no response", n_resp - base, 0);
    send_frame(1'b0, 3'd5, 4'h2, 8'h5A, 1'b0, 1'b0, -1);
    chk("R3 frame after stray", cap_fv, 1);

    // R11: after ack slot, 18 bits without sync produce nothing
    base = n_resp;
    for (int i = 0; i < 18; i++) send_pulse(w0);
    chk("R11 no decision without sync", n_resp - base, 0);

    // R10: fields held while a new frame is partly received
    send_pulse(wsync);
    for (int i = 0; i < 6; i++) send_pulse(w1);
    chk("R10 data held", data_o, 8'h5A);
    chk("R10 raddr held", raddr_o, 4'h2);

    // R8: sync mid-frame restarts
    base = n_resp;
    send_frame(1'b1, 3'd5, 4'h9, 8'hC3, 1'b0, 1'b0, -1);
    chk("R8 one decision", n_resp - base, 1);
    chk("R8 valid", cap_fv, 1);
    chk("R8 data", data_o, 8'hC3);

    // R7: invalid width pulse inside frame
    send_frame(1'b0, 3'd5, 4'h4, 8'h11, 1'b0, 1'b0, 7);
    chk("R7 err", cap_err, 1);
    chk("R7 nack", cap_ack, 0);
    chk("R7 no frame_vld", cap_fv, 0);

    // R2 boundaries: w1 = thr_short-1, w0 = thr_short, MIN_W for ones
    w1 = 5; w0 = 6; wsync = 13;
    send_frame(1'b1, 3'd5, 4'h6, 8'h96, 1'b0, 1'b0, -1);
    chk("R2 low edges valid", cap_fv, 1);
    chk("R2 low edges data", data_o, 8'h96);
    w1 = 2; w0 = 12;
    send_frame(1'b0, 3'd5, 4'hC, 8'h69, 1'b0, 1'b0, -1);
    chk("R2 high edges valid", cap_fv, 1);
    chk("R2 high edges data", data_o, 8'h69);

    // R2: thresholds reprogrammed
    thr_short = 8'd3; thr_long = 8'd8;
    w1 = 2; w0 = 4; wsync = 9;
    send_frame(1'b1, 3'd5, 4'h5, 8'hE1, 1'b0, 1'b0, -1);
    chk("R2 new thresholds valid", cap_fv, 1);
    chk("R2 new thresholds data", data_o, 8'hE1);
    chk("R2 new thresholds raddr", raddr_o, 4'h5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule